// File: doc/BRIEF.md
# Send-to-Receive Event Latency Timestamper

This block measures how long a transmit-side event takes to show up as a receive-side event. Everything runs on the receive clock. A free-running counter provides one common time base. Two event inputs are fed in: the transmitter's "may start a frame now" strobe and the receive stream's start-of-frame strobe. Each is reduced to a one-cycle pulse by rising-edge detection. While monitoring is enabled, each pulse stamps the current counter value into a shared FIFO. Each FIFO entry is tagged as a send or a receive stamp.

Host logic drains the FIFO through a valid/ready read stream. A flag tells the host when the two oldest entries form a send-then-receive pair. For that pair the block also presents a corrected latency. The correction assumes the transmit clock runs 180 degrees out of phase with the receive clock. The receive strobe arrives one sampling cycle late, and the transmit strobe is half a cycle early relative to the receive domain. The corrected latency is therefore the stamp difference minus half a cycle, reported in half-cycle units.

The read side follows valid/ready rules. `rd_valid` is high whenever the FIFO holds an entry. The head entry stays on `rd_ts`/`rd_tag` unchanged until a cycle in which `rd_ready` is also high, which pops it. The capture side has no back-pressure. Events that find no room are lost, and their loss is recorded.

Top module: `evt_latency_mon`

## Requirements
- R1: The timer resets to 0 and increments by one every clock, wrapping modulo 2^TS_W. A capture stores the timer value present just before the clock edge at which the event level is first seen high.
- R2: While `mon_en` is low, no entry is written. The edge detector keeps tracking the inputs regardless of `mon_en`, so a level that rose while disabled is not captured after enabling.
- R3: A capture happens only on a low-to-high change of an event input. A level held high for many cycles yields exactly one entry. The remembered previous level is 0 after reset.
- R4: Tag value 0 marks a send stamp and tag value 1 marks a receive stamp. When both events are detected in the same cycle, the send entry is placed ahead of the receive entry, and both carry the same stamp.
- R5: `rd_valid` is high exactly when the FIFO is not empty. The head entry is shown on `rd_ts`/`rd_tag` and is removed at a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the head stays stable.
- R6: `fifo_level` shows the number of stored entries, updated one clock after each write or pop.
- R7: `pair_avail` is high exactly when at least two entries are stored, the head has tag 0, and the entry behind it has tag 1.
- R8: When `pair_avail` is high, `lat_half` equals 2*((rx - tx) mod 2^TS_W) - 1, taken modulo 2^(TS_W+1). Here tx is the head stamp and rx is the next stamp, so a timer wrap between the two events still gives the true delay.
- R9: An event that finds no free slot is dropped and sets the sticky `ovf` flag. With one slot left and both events in the same cycle, the send entry is kept and the receive entry is dropped. A pop in the same cycle does not make room for a write.
- R10: `ovf` stays set until `ovf_clr` is high at a clock edge. If a drop happens in that same cycle, the flag remains set.
- R11: Synchronous reset empties the FIFO, clears `ovf`, `pair_avail`, the timer and the edge-detect state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_en | input | 1 | Capture enable |
| send_evt | input | 1 | Transmit start-permission strobe level |
| recv_evt | input | 1 | Receive start-of-frame strobe level |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_tag | output | 1 | Head tag, 0 send, 1 receive |
| rd_ts | output | TS_W | Head timestamp |
| fifo_level | output | clog2(DEPTH+1) | Stored entry count |
| pair_avail | output | 1 | Head two entries are a send/receive pair |
| lat_half | output | TS_W+1 | Corrected latency in half cycles |
| ovf | output | 1 | Sticky overflow flag |

## Verification
An event level driven before a clock edge is stamped at that edge. The resulting entry, level, pair flag and latency are visible after that same edge, one register stage later. A pop is also reflected after its edge. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each result is checked exactly one edge after the stimulus that causes it. Expected stamps come from a bench cycle count that is captured when each event level is raised.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic {
    TAG_SEND = 1'b0,
    TAG_RECV = 1'b1
  } ev_tag_e;
endpackage

// File: rtl/lm_event_capture.sv
module lm_event_capture #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            send_lvl,
  input  logic            recv_lvl,
  output logic [TS_W-1:0] stamp,
  output logic            send_hit,
  output logic            recv_hit
);
  logic [TS_W-1:0] tmr_q;
  logic            send_prev_q;
  logic            recv_prev_q;
  logic            up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q       <= '0;
      send_prev_q <= 1'b0;
      recv_prev_q <= 1'b0;
      up_q        <= 1'b0;
    end else begin
      tmr_q       <= tmr_q + 1'b1;
      send_prev_q <= send_lvl;
      recv_prev_q <= recv_lvl;
      up_q        <= 1'b1;
    end
  end

  assign stamp    = tmr_q;
  assign send_hit = en & send_lvl & ~send_prev_q;
  assign recv_hit = en & recv_lvl & ~recv_prev_q;

  // R1: timer advances by exactly one per cycle once out of reset
  p_timer_step_r1: assert property (@(posedge clk) disable iff (rst)
    up_q |-> (tmr_q == $past(tmr_q) + 1'b1));

  // R3: a detected edge is never followed by a second capture of the same level
  p_one_shot_r3: assert property (@(posedge clk) disable iff (rst)
    send_hit |=> !send_hit);
  p_one_shot_rx_r3: assert property (@(posedge clk) disable iff (rst)
    recv_hit |=> !recv_hit);
endmodule

// File: rtl/lm_ts_fifo.sv
module lm_ts_fifo #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_a,
  input  logic             tag_a,
  input  logic             req_b,
  input  logic             tag_b,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic             rd_ready,
  input  logic             ovf_clr,
  output logic             rd_valid,
  output logic             head_tag,
  output logic [TS_W-1:0]  head_ts,
  output logic             next_tag,
  output logic [TS_W-1:0]  next_ts,
  output logic [LVL_W-1:0] level,
  output logic             ovf
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE_LEFT = LVL_W'(DEPTH - 1);

  logic [TS_W:0]    mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q, wp_b, rp_n;
  logic [LVL_W-1:0] lvl_q;
  logic             ovf_q;
  logic             acc_a, acc_b, drop, pop;

  assign acc_a = req_a && (lvl_q != FULL_LVL);
  assign acc_b = req_b && (lvl_q <  ONE_LEFT);
  assign drop  = (req_a && !acc_a) || (req_b && !acc_b);
  assign pop   = rd_valid && rd_ready;
  assign wp_b  = wp_q + 1'b1;
  assign rp_n  = rp_q + 1'b1;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (acc_a && (wp_q == AW'(i)))
        mem[i] <= {tag_a, wr_ts};
      else if (acc_b && (wp_b == AW'(i)))
        mem[i] <= {tag_b, wr_ts};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_q + AW'(acc_a) + AW'(acc_b);
      if (pop) rp_q <= rp_n;
      lvl_q <= lvl_q + LVL_W'(acc_a) + LVL_W'(acc_b) - LVL_W'(pop);
      if (drop)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign rd_valid = (lvl_q != '0);
  assign {head_tag, head_ts} = mem[rp_q];
  assign {next_tag, next_ts} = mem[rp_n];
  assign level = lvl_q;
  assign ovf   = ovf_q;

  // R9: stored count never exceeds capacity
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= FULL_LVL);

  // R10: overflow flag persists until cleared
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R5: head held while host stalls
  p_head_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(head_ts) && $stable(head_tag)));

  // R6: a pop without a write lowers the count by one
  p_pop_level_r6: assert property (@(posedge clk) disable iff (rst)
    (pop && !acc_a) |=> (lvl_q == $past(lvl_q) - 1'b1));
endmodule

// File: rtl/lm_lat_calc.sv
module lm_lat_calc #(
  parameter int TS_W  = 32,
  parameter int LVL_W = 10
) (
  input  logic [LVL_W-1:0] level,
  input  logic             head_tag,
  input  logic [TS_W-1:0]  head_ts,
  input  logic             next_tag,
  input  logic [TS_W-1:0]  next_ts,
  output logic             pair_ok,
  output logic [TS_W:0]    lat_half
);
  import lm_pkg::*;
  logic [TS_W-1:0] span;

  assign pair_ok  = (level >= LVL_W'(2)) && (head_tag == TAG_SEND) && (next_tag == TAG_RECV);
  assign span     = next_ts - head_ts;
  assign lat_half = {span, 1'b0} - {{TS_W{1'b0}}, 1'b1};
endmodule

// File: rtl/evt_latency_mon.sv
module evt_latency_mon #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mon_en,
  input  logic             send_evt,
  input  logic             recv_evt,
  input  logic             ovf_clr,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic             rd_tag,
  output logic [TS_W-1:0]  rd_ts,
  output logic [LVL_W-1:0] fifo_level,
  output logic             pair_avail,
  output logic [TS_W:0]    lat_half,
  output logic             ovf
);
  import lm_pkg::*;

  logic [TS_W-1:0] stamp;
  logic            send_hit, recv_hit;
  logic            req_a, req_b;
  ev_tag_e         tag_a;
  logic            next_tag;
  logic [TS_W-1:0] next_ts;

  lm_event_capture #(.TS_W(TS_W)) cap_i (
    .clk      (clk),
    .rst      (rst),
    .en       (mon_en),
    .send_lvl (send_evt),
    .recv_lvl (recv_evt),
    .stamp    (stamp),
    .send_hit (send_hit),
    .recv_hit (recv_hit)
  );

  // send always takes the first slot when both fire together
  assign req_a = send_hit | recv_hit;
  assign tag_a = send_hit ? TAG_SEND : TAG_RECV;
  assign req_b = send_hit & recv_hit;

  lm_ts_fifo #(.TS_W(TS_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst      (rst),
    .req_a    (req_a),
    .tag_a    (tag_a),
    .req_b    (req_b),
    .tag_b    (TAG_RECV),
    .wr_ts    (stamp),
    .rd_ready (rd_ready),
    .ovf_clr  (ovf_clr),
    .rd_valid (rd_valid),
    .head_tag (rd_tag),
    .head_ts  (rd_ts),
    .next_tag (next_tag),
    .next_ts  (next_ts),
    .level    (fifo_level),
    .ovf      (ovf)
  );

  lm_lat_calc #(.TS_W(TS_W), .LVL_W(LVL_W)) calc_i (
    .level    (fifo_level),
    .head_tag (rd_tag),
    .head_ts  (rd_ts),
    .next_tag (next_tag),
    .next_ts  (next_ts),
    .pair_ok  (pair_avail),
    .lat_half (lat_half)
  );

  // R7: a pair implies two stored entries
  p_pair_depth_r7: assert property (@(posedge clk) disable iff (rst)
    pair_avail |-> (fifo_level >= LVL_W'(2)));

  // R2: nothing is stored while capture is disabled
  p_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!mon_en && !rd_ready) |=> (fifo_level == $past(fifo_level)));
endmodule

// File: tb/evt_latency_mon_tb.sv
`timescale 1ns/1ps
module evt_latency_mon_tb_top;
  localparam int TW = 8;
  localparam int DP = 8;
  localparam int LW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst, mon_en, send_evt, recv_evt, ovf_clr, rd_ready;
  logic          rd_valid, rd_tag, pair_avail, ovf;
  logic [TW-1:0] rd_ts;
  logic [LW-1:0] fifo_level;
  logic [TW:0]   lat_half;
  logic [TW-1:0] tcnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) tcnt <= rst ? '0 : tcnt + 1'b1;

  evt_latency_mon #(.TS_W(TW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .mon_en(mon_en), .send_evt(send_evt), .recv_evt(recv_evt),
    .ovf_clr(ovf_clr), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_ts(rd_ts), .fifo_level(fifo_level), .pair_avail(pair_avail),
    .lat_half(lat_half), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic drain();
    rd_ready = 1'b1;
    while (rd_valid) tick();
    rd_ready = 1'b0;
  endtask

  function automatic int exp_lat(input logic [TW-1:0] tx, input logic [TW-1:0] rx);
    logic [TW-1:0] d;
    logic [TW:0]   l;
    d = rx - tx;
    l = {d, 1'b0} - 1;
    return int'(l);
  endfunction

  localparam int NV = 6;
  localparam int VDLY [NV] = '{1, 2, 3, 6, 17, 40};
  localparam int VGAP [NV] = '{0, 1, 4, 2, 9, 3};

  initial begin
    logic [TW-1:0] t_tx, t_rx;
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] t_tx, t_rx, hold;
    rst = 1'b1; mon_en = 1'b0; send_evt = 1'b0; recv_evt = 1'b0;
    ovf_clr = 1'b0; rd_ready = 1'b0;
    tick(3);
    rst = 1'b0;
    tick();
    // R11 reset state
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 level", fifo_level, 0);
    chk("R11 pair", pair_avail, 0);
    chk("R11 ovf", ovf, 0);
    mon_en = 1'b1;

    // vector table: send, delay, receive, check pair, pop both
    for (int v = 0; v < NV; v++) begin
      tick(VGAP[v]);
      send_evt = 1'b1; t_tx = tcnt;
      tick();
      send_evt = 1'b0;
      tick(VDLY[v] - 1);
      recv_evt = 1'b1; t_rx = tcnt;
      tick();
      recv_evt = 1'b0;
      chk("R6 level pair", fifo_level, 2);
      chk("R7 pair_avail", pair_avail, 1);
      chk("R1 tx stamp", rd_ts, t_tx);
      chk("R8 lat_half", lat_half, exp_lat(t_tx, t_rx));
      rd_ready = 1'b1;
      tick();
      chk("R5 second tag", rd_tag, 1);
      chk("R1 rx stamp", rd_ts, t_rx);
      chk("R7 pair drop", pair_avail, 0);
      tick();
      rd_ready = 1'b0;
      chk("R5 empty", rd_valid, 0);
    end

    // R8 wraparound between send and receive
    while (tcnt != 8'd254) tick();
    send_evt = 1'b1; t_tx = tcnt; tick(); send_evt = 1'b0;
    tick(4);
    recv_evt = 1'b1; t_rx = tcnt; tick(); recv_evt = 1'b0;
    chk("R8 wrap rx", t_rx, 3);
    chk("R8 wrap lat", lat_half, 9);
    drain();

    // R4 same-cycle events
    send_evt = 1'b1; recv_evt = 1'b1; t_tx = tcnt;
    tick();
    send_evt = 1'b0; recv_evt = 1'b0;
    chk("R4 level", fifo_level, 2);
    chk("R4 first tag", rd_tag, 0);
    chk("R4 first ts", rd_ts, t_tx);
    chk("R8 zero span", lat_half, 9'h1FF);
    // R5 head stable while stalled
    hold = rd_ts;
    tick(3);
    chk("R5 hold ts", rd_ts, hold);
    chk("R5 hold valid", rd_valid, 1);
    rd_ready = 1'b1; tick(); rd_ready = 1'b0;
    chk("R4 second tag", rd_tag, 1);
    chk("R4 second ts", rd_ts, t_tx);
    drain();

    // R7 receive before send is not a pair
    recv_evt = 1'b1; tick(); recv_evt = 1'b0; tick();
    send_evt = 1'b1; tick(); send_evt = 1'b0;
    chk("R7 order level", fifo_level, 2);
    chk("R7 wrong order", pair_avail, 0);
    drain();

    // R3 held level captures once
    send_evt = 1'b1; tick(6);
    chk("R3 held", fifo_level, 1);
    send_evt = 1'b0; tick();
    drain();

    // R2 disabled capture, and level risen while disabled
    mon_en = 1'b0;
    send_evt = 1'b1; recv_evt = 1'b1; tick();
    chk("R2 disabled", fifo_level, 0);
    mon_en = 1'b1; tick(2);
    chk("R2 no late capture", fifo_level, 0);
    send_evt = 1'b0; recv_evt = 1'b0; tick();

    // R9 fill to one slot, then both events
    for (int k = 0; k < 3; k++) begin
      send_evt = 1'b1; recv_evt = 1'b1; tick();
      send_evt = 1'b0; recv_evt = 1'b0; tick();
    end
    send_evt = 1'b1; tick(); send_evt = 1'b0; tick();
    chk("R9 level seven", fifo_level, 7);
    chk("R9 no ovf yet", ovf, 0);
    send_evt = 1'b1; recv_evt = 1'b1; tick();
    send_evt = 1'b0; recv_evt = 1'b0;
    chk("R9 full", fifo_level, 8);
    chk("R9 ovf set", ovf, 1);
    tick();
    // R9 pop and push in one cycle while full: push lost
    rd_ready = 1'b1; send_evt = 1'b1; tick();
    rd_ready = 1'b0; send_evt = 1'b0;
    chk("R9 pop no room", fifo_level, 7);
    rd_ready = 1'b1; tick(5); rd_ready = 1'b0;
    chk("R9 kept send tag", rd_tag, 0);
    chk("R10 sticky", ovf, 1);
    drain();
    chk("R10 still set", ovf, 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    chk("R10 cleared", ovf, 0);

    // R11 reset with stored entries
    send_evt = 1'b1; tick(); send_evt = 1'b0; tick();
    chk("R11 pre", fifo_level, 1);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R11 flush", fifo_level, 0);
    chk("R11 valid", rd_valid, 0);
    chk("R1 timer restart", tcnt, 0);
    send_evt = 1'b1; tick(); send_evt = 1'b0;
    chk("R1 stamp after reset", rd_ts, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule